// File: doc/BRIEF.md
# Multiphase Regulator Power-State Sequencer

This block is the digital mode controller of a multiphase buck regulator core. It takes decoded commands from a serial voltage-identification front end. A power-state command selects one of three modes. In full-phase continuous conduction, every phase switches. In single-phase continuous conduction, only phase 1 switches. In single-phase diode emulation, only phase 1 switches and it runs in discontinuous mode. For each phase the block drives a PWM enable. When that enable is low, the driver of that phase holds its PWM pin in high impedance. The block also raises a diode-emulation flag that the ramp generator uses to select its discontinuous-mode setting.

A voltage-target command always returns the regulator to full-phase mode. It also cancels any earlier power-state request, and that request stays cancelled after the new voltage is reached. While the voltage ramp is running, the block sends the ramp direction and a current code to a compensation-current source. The code selects a high current for a fast rising slew and a quarter of that current for a slow rising slew. On a falling ramp the code is zero. A power-state command that arrives during a ramp is held and applied when the DAC reports that the target is reached.

Top module: `ps_sequencer`

## Requirements
- R1: After reset, `mode` is 0 (full phase), every bit of `pwm_en` is 1, and `dem_en`, `dvid_up`, `dvid_code`, `ps_err` and `ramping` are all 0.
- R2: A power-state command with code 1, accepted while no ramp is running, gives `mode`=1 and `pwm_en`=1 on phase 0 only, with `dem_en`=0.
- R3: A power-state command with code 2 gives `mode`=2, `pwm_en`=1 on phase 0 only and `dem_en`=1. `dem_en` is 1 in no other mode.
- R4: An accepted power-state command takes effect at the first rising clock edge that samples its strobe. There is no extra wait.
- R5: A voltage command gives `mode`=0, all `pwm_en` bits 1 and `ramping`=1 from the next edge on, whatever the previous mode was.
- R6: When `tgt_reached` ends a ramp and no request was held, `mode` stays 0. The power state that was in force before the voltage command is not restored.
- R7: A valid power-state command received while `ramping`=1 is held, and a later one replaces it. The held code is applied at the same edge that samples `tgt_reached` and clears `ramping`.
- R8: During a rising ramp, `dvid_up`=1. `dvid_code` equals DVID_FAST when the command had its fast flag set, and DVID_FAST/4 when it did not.
- R9: During a falling ramp, `dvid_up`=0 and `dvid_code`=0.
- R10: A power-state code of 3 is rejected. `mode` and any held request stay unchanged, and `ps_err` is 1 for exactly the one cycle after the strobe.
- R11: When a voltage command and a power-state command arrive in the same cycle, the voltage command wins and the power-state command is discarded.
- R12: `tgt_reached` has no effect while no ramp is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps_vld | input | 1 | Power-state command strobe |
| ps_code | input | 2 | Requested state: 0 full, 1 single CCM, 2 single diode emulation |
| vid_vld | input | 1 | Voltage-target command strobe |
| vid_up | input | 1 | Direction of the new target: 1 means higher |
| vid_fast | input | 1 | Slew class: 1 means fast, 0 means slow (quarter rate) |
| tgt_reached | input | 1 | DAC ramp has reached its target |
| mode | output | 2 | Current power state |
| pwm_en | output | NPHASE | Per-phase switching enable; 0 means tri-state |
| dem_en | output | 1 | Diode-emulation flag |
| ramping | output | 1 | A voltage transition is in progress |
| dvid_up | output | 1 | Rising transition in progress |
| dvid_code | output | DVID_W | Compensation-current code |
| ps_err | output | 1 | One-cycle pulse on a rejected state code |

## Verification
The bench builds the block with NPHASE=4 and DVID_FAST=12. The fourth phase shows that the generated enables tri-state every phase beyond the first, not just a fixed pair. With DVID_FAST=12 the slow code is 3, so the quarter-rate division can be checked against a value other than the default 8/2 pair. The default DVID_W of 4 still holds the fast code.

// File: rtl/ps_sequencer.sv
module ps_sequencer #(
  parameter int NPHASE    = 3,
  parameter int DVID_W    = 4,
  parameter int DVID_FAST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ps_vld,
  input  logic [1:0]        ps_code,
  input  logic              vid_vld,
  input  logic              vid_up,
  input  logic              vid_fast,
  input  logic              tgt_reached,
  output logic [1:0]        mode,
  output logic [NPHASE-1:0] pwm_en,
  output logic              dem_en,
  output logic              ramping,
  output logic              dvid_up,
  output logic [DVID_W-1:0] dvid_code,
  output logic              ps_err
);
  localparam logic [1:0] FULL = 2'd0;
  localparam logic [1:0] DEM  = 2'd2;
  localparam logic [DVID_W-1:0] CODE_FAST = DVID_W'(DVID_FAST);
  localparam logic [DVID_W-1:0] CODE_SLOW = DVID_W'(DVID_FAST / 4);

  logic       up_q, fast_q, hold_v;
  logic [1:0] hold_code;

  wire ps_ok  = ps_vld && (ps_code != 2'd3);
  wire finish = ramping && tgt_reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= FULL;
      ramping   <= 1'b0;
      up_q      <= 1'b0;
      fast_q    <= 1'b0;
      hold_v    <= 1'b0;
      hold_code <= FULL;
      ps_err    <= 1'b0;
    end else begin
      ps_err <= ps_vld && !ps_ok;
      if (vid_vld) begin
        mode    <= FULL;
        ramping <= 1'b1;
        up_q    <= vid_up;
        fast_q  <= vid_fast;
        hold_v  <= 1'b0;
      end else if (finish) begin
        ramping <= 1'b0;
        hold_v  <= 1'b0;
        if (ps_ok)       mode <= ps_code;
        else if (hold_v) mode <= hold_code;
      end else if (ps_ok) begin
        if (ramping) begin
          hold_v    <= 1'b1;
          hold_code <= ps_code;
        end else begin
          mode <= ps_code;
        end
      end
    end
  end

  for (genvar p = 0; p < NPHASE; p++) begin : g_phase
    if (p == 0) begin : g_main
      assign pwm_en[p] = 1'b1;
    end else begin : g_aux
      assign pwm_en[p] = (mode == FULL);
    end
  end

  assign dem_en    = (mode == DEM);
  assign dvid_up   = ramping && up_q;
  assign dvid_code = dvid_up ? (fast_q ? CODE_FAST : CODE_SLOW) : '0;
endmodule

// File: rtl/ps_sequencer_chk.sv
module ps_sequencer_chk #(
  parameter int NPHASE    = 3,
  parameter int DVID_W    = 4,
  parameter int DVID_FAST = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ps_vld,
  input logic [1:0]        ps_code,
  input logic              vid_vld,
  input logic              vid_up,
  input logic              vid_fast,
  input logic [1:0]        mode,
  input logic [NPHASE-1:0] pwm_en,
  input logic              dem_en,
  input logic              ramping,
  input logic [DVID_W-1:0] dvid_code,
  input logic              ps_err
);
  localparam logic [NPHASE-1:0] ONE = NPHASE'(1);

  AST_VID_FORCES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    vid_vld |=> (mode == 2'd0) && (&pwm_en) && ramping); // R5
  AST_SINGLE_CCM: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_vld && ps_code == 2'd1 && !vid_vld && !ramping) |=> (mode == 2'd1) && (pwm_en == ONE)); // R2
  AST_DEM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dem_en |-> (pwm_en == ONE) && (mode == 2'd2)); // R3
  AST_REJECT_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ps_err |-> $stable(mode)); // R10
  AST_DOWN_NO_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_vld && !vid_up) |=> (dvid_code == '0)); // R9
  AST_UP_FAST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_vld && vid_up && vid_fast) |=> (dvid_code == DVID_W'(DVID_FAST))); // R8
endmodule

bind ps_sequencer ps_sequencer_chk #(.NPHASE(NPHASE), .DVID_W(DVID_W), .DVID_FAST(DVID_FAST)) u_chk (
  .clk(clk), .rst_n(rst_n), .ps_vld(ps_vld), .ps_code(ps_code), .vid_vld(vid_vld),
  .vid_up(vid_up), .vid_fast(vid_fast), .mode(mode), .pwm_en(pwm_en), .dem_en(dem_en),
  .ramping(ramping), .dvid_code(dvid_code), .ps_err(ps_err)
);

// File: tb/sim_ps_sequencer.sv
module sim_ps_sequencer;
  localparam int NP = 4;
  localparam int DW = 4;
  localparam int DF = 12;
  localparam int EW = 2 + NP + 1 + 1 + 1 + DW + 1;

  logic clk = 0, rst_n = 0;
  logic ps_vld = 0, vid_vld = 0, vid_up = 0, vid_fast = 0, tgt_reached = 0;
  logic [1:0] ps_code = 0;
  logic [1:0] mode;
  logic [NP-1:0] pwm_en;
  logic dem_en, ramping, dvid_up, ps_err;
  logic [DW-1:0] dvid_code;

  int checks = 0, errors = 0, cyc = 0;
  logic [EW-1:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  ps_sequencer #(.NPHASE(NP), .DVID_W(DW), .DVID_FAST(DF)) u0 (
    .clk(clk), .rst_n(rst_n), .ps_vld(ps_vld), .ps_code(ps_code), .vid_vld(vid_vld),
    .vid_up(vid_up), .vid_fast(vid_fast), .tgt_reached(tgt_reached), .mode(mode),
    .pwm_en(pwm_en), .dem_en(dem_en), .ramping(ramping), .dvid_up(dvid_up),
    .dvid_code(dvid_code), .ps_err(ps_err));

  wire [EW-1:0] act = {mode, pwm_en, dem_en, ramping, dvid_up, dvid_code, ps_err};

  function automatic logic [EW-1:0] pack(input logic [1:0] m, input logic r, input logic u,
                                         input int code, input logic e);
    logic [NP-1:0] en = (m == 2'd0) ? {NP{1'b1}} : NP'(1);
    return {m, en, (m == 2'd2), r, u, DW'(code), e};
  endfunction

  task automatic compare(input logic [EW-1:0] e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, e);
    end
  endtask

  task automatic step(input logic pv, input logic [1:0] pc, input logic vv, input logic up,
                      input logic fa, input logic tg, input logic [1:0] m, input logic r,
                      input logic u, input int code, input logic e, input string tag);
    @(negedge clk);
    ps_vld = pv; ps_code = pc; vid_vld = vv; vid_up = up; vid_fast = fa; tgt_reached = tg;
    exp_q.push_back(pack(m, r, u, code, e));
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(pack(2'd0, 0, 0, 0, 0), "R1 in reset");
    rst_n = 1;
    step(0,0,0,0,0,0, 2'd0,0,0,0,0, "R1 idle after reset");
    step(1,1,0,0,0,0, 2'd1,0,0,0,0, "R2 R4 single ccm");
    step(0,0,0,0,0,0, 2'd1,0,0,0,0, "R2 holds");
    step(1,2,0,0,0,0, 2'd2,0,0,0,0, "R3 diode emulation");
    step(1,3,0,0,0,0, 2'd2,0,0,0,1, "R10 reject code");
    step(0,0,0,0,0,0, 2'd2,0,0,0,0, "R10 err one cycle");
    step(0,0,1,1,1,0, 2'd0,1,1,DF,0, "R5 R8 up fast");
    step(1,1,0,0,0,0, 2'd0,1,1,DF,0, "R7 held first");
    step(1,2,0,0,0,0, 2'd0,1,1,DF,0, "R7 held replaced");
    step(0,0,0,0,0,1, 2'd2,0,0,0,0, "R7 applied at target");
    step(0,0,1,0,0,0, 2'd0,1,0,0,0, "R9 down no current");
    step(0,0,0,0,0,1, 2'd0,0,0,0,0, "R6 no restore");
    step(0,0,0,0,0,0, 2'd0,0,0,0,0, "R6 stays full");
    step(0,0,1,1,0,0, 2'd0,1,1,DF/4,0, "R8 up slow quarter");
    step(0,0,0,0,0,1, 2'd0,0,0,0,0, "R6 end slow ramp");
    step(1,1,0,0,0,0, 2'd1,0,0,0,0, "R2 again");
    step(0,0,0,0,0,1, 2'd1,0,0,0,0, "R12 tgt ignored idle");
    step(1,1,1,1,1,0, 2'd0,1,1,DF,0, "R11 vid wins");
    step(0,0,0,0,0,1, 2'd0,0,0,0,0, "R11 ps discarded");
    step(0,0,1,1,1,0, 2'd0,1,1,DF,0, "R5 ramp again");
    step(1,3,0,0,0,0, 2'd0,1,1,DF,1, "R10 reject during ramp");
    step(0,0,0,0,0,1, 2'd0,0,0,0,0, "R10 nothing held");
    step(0,0,0,0,0,0, 2'd0,0,0,0,0, "R1 final idle");
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 2000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule